// File: doc/BRIEF.md
# Run-of-Ones Position Finder

This block searches a 32-bit word for the lowest group of consecutive 1 bits that is at least as long as a requested length, or exactly that long. It reports whether such a group exists and the bit position where the group begins. The requested length is a runtime input from 0 to 32. A 2-bit alignment selector can restrict the allowed start positions to even bits, to multiples of four or to multiples of eight.

The search is iterative. Each clock folds the word onto a shifted copy of itself with a logical AND. Each shift is half of the length still to cover. After the folds, every surviving 1 marks a position where a long enough group begins. In exact mode, a further filter clears any survivor that has a set neighbour. The survivors are then masked by the alignment selector, and the lowest remaining bit is encoded.

The controller has three states. `ST_IDLE` waits for `start`. `ST_REDUCE` performs one fold per clock. `ST_SCAN` filters, masks and encodes the result. The transitions are:
- idle-to-reduce: `start` with a length of 2 or more.
- idle-to-scan: `start` with a length of 0 or 1.
- reduce-to-reduce: the remaining length after a fold is still above 1.
- reduce-to-scan: the remaining length after a fold is 1 or less.
- scan-to-idle: always, with `done` raised.

The caller holds all operand inputs stable from `start` until `done`.

Top module: `run_finder`

## Requirements
- R1: After reset, `done`, `found` and `index` are all 0, and the block waits for `start`.
- R2: With `exact_mode`=0 and a length n from 1 to 32, the result is the lowest position i such that bits i through i+n-1 all lie inside the word and are all 1. For example, 0x47FDBC69 with n=4 gives index 10.
- R3: With `exact_mode`=1 and n of 1 or more, a start position i must also have bit i-1 equal to 0 (or i=0), and bit i+n equal to 0 (or i+n=32).
- R4: `align_sel` restricts the allowed start positions by its encoding:
  - 0: any position.
  - 1: even positions (0x55555555).
  - 2: multiples of 4 (0x11111111).
  - 3: multiples of 8 (0x01010101).
- R5: When no allowed start position qualifies, `found`=0 and `index`=0.
- R6: A length of 0 reports `found`=1 and `index`=0, in any mode and with any alignment.
- R7: Let the start edge be the clock edge that samples `start` while idle. `done` is high for exactly one cycle, following the edge ceil(log2(max(n,1)))+1 edges after the start edge. `found` and `index` change only on that edge and hold until the next result.
- R8: A `start` that arrives while an operation is in progress is ignored. It neither restarts the operation nor delays its `done`, and it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| data_in | input | 32 | Word to search; held until done |
| run_len | input | 6 | Required length, 0 to 32; held until done |
| exact_mode | input | 1 | 1 selects exact-length matching; held until done |
| align_sel | input | 2 | Start alignment: 0 any, 1 even, 2 by 4, 3 by 8 |
| done | output | 1 | One-cycle pulse when the result is updated |
| found | output | 1 | A qualifying start position exists |
| index | output | 5 | Lowest qualifying start position, 0 if none |

## Verification
A search with length n produces its result ceil(log2(max(n,1)))+1 edges after the start edge. For n of 0 or 1 that is the very next edge; for n=32 it is six edges later. The bench drives inputs on falling edges and computes that latency independently for each search. On every falling edge it compares `done` against the cycle in which the result is due, so an early, late, doubled or missing pulse is reported. It compares `found` and `index` in the due cycle, and checks on the cycle after that the pulse has ended. The expected match comes from a direct scan of every start position, and a repeated `start` during a search is checked to leave that timing unchanged.

// File: rtl/run_finder_pkg.sv
package run_finder_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REDUCE,
        ST_SCAN
    } rf_state_e;

    typedef enum logic [1:0] {
        ALIGN_ANY  = 2'd0,
        ALIGN_EVEN = 2'd1,
        ALIGN_QUAD = 2'd2,
        ALIGN_OCT  = 2'd3
    } rf_align_e;
endpackage

// File: rtl/run_fold_step.sv
module run_fold_step #(
    parameter int W    = 32,
    parameter int LENW = 6
) (
    input  logic [W-1:0]    x_in,
    input  logic [LENW-1:0] rem_in,
    output logic [W-1:0]    x_out,
    output logic [LENW-1:0] rem_out
);
    logic [LENW-1:0] shamt;

    always_comb begin
        shamt   = rem_in >> 1;
        x_out   = x_in & (x_in >> shamt);
        rem_out = rem_in - shamt;
    end
endmodule

// File: rtl/run_exact_filter.sv
module run_exact_filter #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_in,
    input  logic         enable,
    output logic [W-1:0] x_out
);
    always_comb begin
        if (enable)
            x_out = x_in & ~(x_in << 1) & ~(x_in >> 1);
        else
            x_out = x_in;
    end
endmodule

// File: rtl/run_low_scan.sv
module run_low_scan #(
    parameter int W    = 32,
    parameter int IDXW = 5
) (
    input  logic [W-1:0]    vec,
    output logic            any,
    output logic [IDXW-1:0] pos
);
    always_comb begin
        any = |vec;
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i])
                pos = IDXW'(i);
        end
    end
endmodule

// File: rtl/run_finder.sv
module run_finder
    import run_finder_pkg::*;
#(
    parameter int W    = 32,
    parameter int IDXW = $clog2(W),
    parameter int LENW = $clog2(W) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    data_in,
    input  logic [LENW-1:0] run_len,
    input  logic            exact_mode,
    input  logic [1:0]      align_sel,
    output logic            done,
    output logic            found,
    output logic [IDXW-1:0] index
);
    rf_state_e       state_q, state_d;
    logic [W-1:0]    x_q;
    logic [LENW-1:0] rem_q;
    logic [W-1:0]    x_fold;
    logic [LENW-1:0] rem_fold;
    logic [W-1:0]    x_iso;
    logic [W-1:0]    start_mask;
    logic            scan_any;
    logic [IDXW-1:0] scan_pos;
    logic            done_q, found_q;
    logic [IDXW-1:0] index_q;

    run_fold_step #(.W(W), .LENW(LENW)) u_fold (
        .x_in   (x_q),
        .rem_in (rem_q),
        .x_out  (x_fold),
        .rem_out(rem_fold)
    );

    run_exact_filter #(.W(W)) u_iso (
        .x_in  (x_q),
        .enable(exact_mode),
        .x_out (x_iso)
    );

    always_comb begin
        for (int i = 0; i < W; i++)
            start_mask[i] = ((i % (1 << align_sel)) == 0);
    end

    run_low_scan #(.W(W), .IDXW(IDXW)) u_scan (
        .vec(x_iso & start_mask),
        .any(scan_any),
        .pos(scan_pos)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (run_len > LENW'(1)) ? ST_REDUCE : ST_SCAN;
            ST_REDUCE: if (rem_fold <= LENW'(1)) state_d = ST_SCAN;
            ST_SCAN:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q   <= '0;
            rem_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            x_q   <= data_in;
            rem_q <= run_len;
        end else if (state_q == ST_REDUCE) begin
            x_q   <= x_fold;
            rem_q <= rem_fold;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            found_q <= 1'b0;
            index_q <= '0;
        end else begin
            done_q <= (state_q == ST_SCAN);
            if (state_q == ST_SCAN) begin
                if (rem_q == '0) begin
                    found_q <= 1'b1;
                    index_q <= '0;
                end else begin
                    found_q <= scan_any;
                    index_q <= scan_pos;
                end
            end
        end
    end

    assign done  = done_q;
    assign found = found_q;
    assign index = index_q;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    a_r7_reduce_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REDUCE) |-> (rem_q > LENW'(1)));

    a_r5_no_match_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !found_q) |-> (index_q == '0));

    a_r6_zero_length_found: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && run_len == '0) |-> (found_q && index_q == '0));

    a_r4_start_bit_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && found_q && run_len != '0) |-> (data_in[index_q] && start_mask[index_q]));

    a_r3_exact_left_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && found_q && exact_mode && run_len != '0 && index_q != '0)
            |-> !data_in[index_q - IDXW'(1)]);
endmodule

// File: tb/run_finder_test.sv
module run_finder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] data_in = '0;
    logic [5:0]  run_len = '0;
    logic        exact_mode = 1'b0;
    logic [1:0]  align_sel = '0;
    logic        done, found;
    logic [4:0]  index;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    run_finder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .run_len(run_len), .exact_mode(exact_mode), .align_sel(align_sel),
        .done(done), .found(found), .index(index)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void ref_model(input logic [31:0] w, input int n, input bit ex,
                                      input int al, output bit f, output int idx);
        int stride;
        stride = 1 << al;
        f = 0;
        idx = 0;
        if (n == 0) begin
            f = 1;
            return;
        end
        for (int i = 0; i < 32; i++) begin
            bit ok;
            ok = (i % stride) == 0;
            for (int j = 0; j < n; j++)
                if (i + j > 31 || !w[i + j]) ok = 0;
            if (ex && i > 0 && w[i - 1]) ok = 0;
            if (ex && i + n < 32 && w[i + n]) ok = 0;
            if (ok && !f) begin
                f = 1;
                idx = i;
            end
        end
    endfunction

    task automatic run_op(input string req, input logic [31:0] w, input int n, input bit ex,
                          input int al, input bit busy_start);
        bit ef;
        int ei, lat;
        ref_model(w, n, ex, al, ef, ei);
        lat = $clog2((n < 1) ? 1 : n) + 2;
        @(negedge clk);
        data_in = w;
        run_len = 6'(n);
        exact_mode = ex;
        align_sel = 2'(al);
        start = 1'b1;
        for (int cyc = 1; cyc <= lat + 1; cyc++) begin
            @(negedge clk);
            start = (busy_start && cyc == 1);
            check({req, " R7 done timing"}, int'(done), int'(cyc == lat));
            if (cyc == lat) begin
                check({req, " found"}, int'(found), int'(ef));
                check({req, " index"}, int'(index), ei);
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset done", int'(done), 0);
        check("R1 reset found", int'(found), 0);
        check("R1 reset index", int'(index), 0);
        rst_n = 1'b1;
        run_op("R2 example", 32'h47FDBC69, 4, 0, 0, 0);
        run_op("R2 single bit", 32'h00010000, 1, 0, 0, 0);
        run_op("R2 full word", 32'hFFFFFFFF, 32, 0, 0, 0);
        run_op("R5 almost full", 32'hFFFFFFFE, 32, 0, 0, 0);
        run_op("R2 top run", 32'hF0000000, 4, 0, 0, 0);
        run_op("R5 top edge", 32'hE0000000, 4, 0, 0, 0);
        run_op("R2 at least", 32'h0000071F, 3, 0, 0, 0);
        run_op("R3 exact", 32'h0000071F, 3, 1, 0, 0);
        run_op("R3 exact long", 32'h7FFFFFFF, 31, 1, 0, 0);
        run_op("R3 exact single", 32'h00000D36, 1, 1, 0, 0);
        run_op("R5 exact none", 32'h0000FFFF, 5, 1, 0, 0);
        run_op("R4 even", 32'h0000000E, 2, 0, 1, 0);
        run_op("R4 nibble none", 32'h000001E0, 4, 0, 2, 0);
        run_op("R4 nibble", 32'h00001FE0, 4, 0, 2, 0);
        run_op("R4 byte", 32'h0000FF80, 8, 0, 3, 0);
        run_op("R6 zero len", 32'h00000000, 0, 1, 3, 0);
        run_op("R5 empty", 32'h00000000, 1, 0, 0, 0);
        run_op("R8 busy start", 32'h47FDBC69, 4, 0, 0, 1);
        run_op("R8 busy start long", 32'h00FFFF00, 16, 1, 0, 1);
        for (int k = 0; k < 60; k++) begin
            logic [31:0] w;
            w = $urandom | $urandom;
            run_op("R2 R3 R4 random", w, int'($urandom_range(0, 9)),
                   bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), 0);
        end
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule